// File: doc/BRIEF.md
# Global-History Correlated Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using the outcomes of the most recent branches anywhere in the program rather than only that branch's own past. A shift register keeps the last `HIST_LEN` resolved outcomes. The pattern table is split into `2^HIST_LEN` partitions of `2^IDX_W` two-bit saturating counters each. The current history picks the partition. Low-order bits of the branch address pick the row inside it.

On the fetch side, a PC goes in and a taken/not-taken guess comes out combinationally in the same cycle. The current history is also presented on an output so the pipeline can carry it with the branch. When the branch resolves, the resolve side gets the branch PC, the real outcome and the history snapshot that travelled with it. It then trains the counter that produced the guess and shifts the outcome into the global history.

Top module: `gbp_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and the history output is zero, so every PC is predicted not taken.
- R2: `predTaken` is bit 1 of the selected counter (values 2 and 3 mean taken, 0 and 1 mean not taken) and follows `predPc` in the same cycle.
- R3: The counter index is `{history, pc[PC_LSB+IDX_W-1:PC_LSB]}`. The history forms the upper part and picks the partition; the address bits pick the row. PC bits outside that field have no effect on the prediction.
- R4: An update with outcome taken raises the addressed counter by one and holds it at 3.
- R5: An update with outcome not taken lowers the addressed counter by one and holds it at 0.
- R6: An update trains the entry indexed by `updPc` and `updHist`, not by the live history.
- R7: Each update shifts the history one place toward the MSB and puts the outcome (1 = taken) into bit 0. Without an update the history holds.
- R8: When a prediction and an update address the same entry in one cycle, the prediction shows the counter value from before that update.
- R9: The guess flips only after two consecutive outcomes against it: a single opposite outcome from a saturated counter leaves the prediction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| predPc | input | PC_W | Fetch-side branch address |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predHist | output | HIST_LEN | Current global history; snapshot to carry with the branch |
| updValid | input | 1 | Resolve-side update strobe |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Actual outcome, 1 = taken |
| updHist | input | HIST_LEN | History snapshot taken at prediction time |

## Verification
The bench builds the predictor with `HIST_LEN=3`, `IDX_W=3`, `PC_W=16` and `PC_LSB=2`, which gives 64 counters. With a table that small, a few thousand random updates drive many entries through both saturation limits. Random snapshot values reach all eight partitions, and random upper PC bits test that they are ignored. Directed sequences cover saturation, hysteresis, training through a stale snapshot, and a same-cycle read and write of one entry.

// File: rtl/gbp_pkg.sv
package gbp_pkg;
  // Strobes from control to datapath for one resolve event
  typedef struct packed {
    logic shift;    // push an outcome into the global history
    logic inc;      // raise the addressed counter
    logic dec;      // lower the addressed counter
    logic outcome;  // resolved direction, 1 = taken
  } gbp_strobe_t;

  localparam logic [1:0] CNT_MAX  = 2'b11;
  localparam logic [1:0] CNT_MIN  = 2'b00;
  localparam logic [1:0] CNT_INIT = 2'b01;
endpackage

// File: rtl/gbp_ctrl.sv
module gbp_ctrl
  import gbp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        updValid,
  input  logic        updTaken,
  input  logic [1:0]  updCnt,
  output gbp_strobe_t strb
);
  always_comb begin
    strb.shift   = updValid;
    strb.outcome = updTaken;
    strb.inc     = updValid && updTaken && (updCnt != CNT_MAX);
    strb.dec     = updValid && !updTaken && (updCnt != CNT_MIN);
  end

  // R4 R5: a counter never moves both ways in one cycle
  a_r4_r5_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.inc, strb.dec}));
  // R9: a taken outcome can never weaken a counter
  a_r9_taken_no_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && updTaken) |-> !strb.dec);
endmodule

// File: rtl/gbp_datapath.sv
module gbp_datapath
  import gbp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int IDX_W    = 4,
  parameter int HIST_LEN = 4
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PC_W-1:0]     predPc,
  input  logic [PC_W-1:0]     updPc,
  input  logic [HIST_LEN-1:0] updHist,
  input  gbp_strobe_t         strb,
  output logic                predTaken,
  output logic [HIST_LEN-1:0] curHist,
  output logic [1:0]          updCnt
);
  localparam int TBL_W = HIST_LEN + IDX_W;
  localparam int DEPTH = 1 << TBL_W;

  logic [1:0]          cntQ [DEPTH];
  logic [HIST_LEN-1:0] histQ;
  logic [TBL_W-1:0]    predIdx, updIdx;

  assign predIdx   = {histQ,   predPc[PC_LSB+IDX_W-1:PC_LSB]};
  assign updIdx    = {updHist, updPc[PC_LSB+IDX_W-1:PC_LSB]};
  assign predTaken = cntQ[predIdx][1];
  assign updCnt    = cntQ[updIdx];
  assign curHist   = histQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cntQ[i] <= CNT_INIT;
      histQ <= '0;
    end else begin
      if (strb.inc)      cntQ[updIdx] <= updCnt + 2'd1;
      else if (strb.dec) cntQ[updIdx] <= updCnt - 2'd1;
      if (strb.shift) histQ <= (histQ << 1) | HIST_LEN'(strb.outcome);
    end
  end

  // R4: control never asks for a raise past the top
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    strb.inc |-> (updCnt != CNT_MAX));
  // R5: control never asks for a drop below the bottom
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    strb.dec |-> (updCnt != CNT_MIN));
  // R7: the new bit 0 is the outcome that was shifted in
  a_r7_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    strb.shift |=> (histQ[0] == $past(strb.outcome)));
  // R7: history holds when nothing resolves
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.shift |=> $stable(histQ));
endmodule

// File: rtl/gbp_predictor.sv
module gbp_predictor
  import gbp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int IDX_W    = 4,
  parameter int HIST_LEN = 4
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PC_W-1:0]     predPc,
  output logic                predTaken,
  output logic [HIST_LEN-1:0] predHist,
  input  logic                updValid,
  input  logic [PC_W-1:0]     updPc,
  input  logic                updTaken,
  input  logic [HIST_LEN-1:0] updHist
);
  gbp_strobe_t strb;
  logic [1:0]  updCnt;

  gbp_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .updValid(updValid), .updTaken(updTaken),
    .updCnt(updCnt), .strb(strb)
  );

  gbp_datapath #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_LEN(HIST_LEN)) dp_i (
    .clk(clk), .rst_n(rst_n), .predPc(predPc), .updPc(updPc), .updHist(updHist),
    .strb(strb), .predTaken(predTaken), .curHist(predHist), .updCnt(updCnt)
  );
endmodule

// File: tb/gbp_predictor_tb_top.sv
module gbp_predictor_tb_top;
  localparam int CLK_P = 10;
  localparam int PC_W = 16, PC_LSB = 2, IDX_W = 3, HIST_LEN = 3;
  localparam int DEPTH = 1 << (HIST_LEN + IDX_W);

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] predPc = '0, updPc = '0;
  logic updValid = 0, updTaken = 0;
  logic [HIST_LEN-1:0] updHist = '0;
  logic predTaken;
  logic [HIST_LEN-1:0] predHist;

  int total = 0, bad = 0;
  int mdl [DEPTH];
  logic [HIST_LEN-1:0] mh;

  always #(CLK_P/2) clk = ~clk;

  gbp_predictor #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_LEN(HIST_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .predPc(predPc), .predTaken(predTaken), .predHist(predHist),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .updHist(updHist)
  );

  function automatic int idxOf(logic [PC_W-1:0] pc, logic [HIST_LEN-1:0] h);
    return int'({h, pc[PC_LSB+IDX_W-1:PC_LSB]});
  endfunction

  function automatic int nextCnt(int c, bit t);
    if (t) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive, check prediction and history before the edge, then update the model
  task automatic step(string req, logic [PC_W-1:0] pc, bit uv,
                      logic [PC_W-1:0] upc, bit ut, logic [HIST_LEN-1:0] uh);
    int e;
    @(negedge clk);
    predPc = pc; updValid = uv; updPc = upc; updTaken = ut; updHist = uh;
    #1;
    e = (mdl[idxOf(pc, mh)] >= 2) ? 1 : 0;
    check(predTaken == e[0], req, int'(predTaken), e);
    check(predHist == mh, "R7 history", int'(predHist), int'(mh));
    @(posedge clk);
    if (uv) begin
      mdl[idxOf(upc, uh)] = nextCnt(mdl[idxOf(upc, uh)], ut);
      mh = {mh[HIST_LEN-2:0], ut};
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) mdl[i] = 1;
    mh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: every row in partition 0 reads not taken, history zero
    for (int r = 0; r < (1 << IDX_W); r++)
      step("R1 reset", PC_W'(r << PC_LSB), 0, '0, 0, '0);
    check(predHist == '0, "R1 history", int'(predHist), 0);

    // R4 R9: saturate row 4 of partition 0, then one not-taken keeps taken
    for (int i = 0; i < 4; i++) step("R4 raise", 16'h0010, 1, 16'h0010, 1, 3'd0);
    step("R9 one wrong", 16'h0010, 1, 16'h0010, 0, 3'd0);
    // clear history to 0 through another entry, then observe row 4 of partition 0
    for (int i = 0; i < 3; i++) step("R6 shift", 16'h001c, 1, 16'h001c, 0, 3'd7);
    step("R9 still taken", 16'h0010, 0, '0, 0, '0);
    check(predTaken == 1'b1, "R9 hysteresis", int'(predTaken), 1);
    // R3: upper PC bits ignored
    step("R3 upper bits", 16'hff10, 0, '0, 0, '0);
    check(predTaken == 1'b1, "R3 upper bits", int'(predTaken), 1);

    // R5: drive the same entry to the floor and past it
    for (int i = 0; i < 5; i++) step("R5 lower", 16'h0010, 1, 16'h0010, 0, 3'd0);
    for (int i = 0; i < 2; i++) step("R5 floor", 16'h0010, 1, 16'h0010, 1, mh);

    // R8: same entry read and trained in one cycle shows the old value
    for (int i = 0; i < 4; i++) step("R8 same cycle", 16'h0008, 1, 16'h0008, 1, mh);

    // Random mix: R2 R3 R6 R7 with stale or live snapshots and idle cycles
    for (int i = 0; i < 4000; i++) begin
      logic [PC_W-1:0] p, u;
      logic [HIST_LEN-1:0] h;
      p = PC_W'($urandom);
      u = ($urandom_range(0, 3) == 0) ? p : PC_W'($urandom);
      h = ($urandom_range(0, 1) == 0) ? mh : HIST_LEN'($urandom);
      step("R2 R6 random", p, ($urandom_range(0, 3) != 0), u, bit'($urandom_range(0, 1)), h);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule